// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit connects a 32-bit integer core to a word-wide data memory. It handles five memory operations: word load, word store, signed byte load, unsigned byte load and byte store. The core presents one request per cycle. A request carries a 6-bit opcode, a base register value, a 16-bit immediate and store data. The unit computes the effective address and drives a word address, byte enables, write data and strobes to the memory. For a load, it turns the memory's read data into a 32-bit result.

The memory returns read data one cycle after the read strobe. A small state machine tracks the pending load. It has two states. ST_IDLE means no load result is due. ST_LOAD_WAIT means read data arrives this cycle and the result is delivered. The transitions are:

- ST_IDLE goes to ST_LOAD_WAIT when an aligned load is accepted.
- ST_LOAD_WAIT stays in ST_LOAD_WAIT when a further aligned load is accepted in that same cycle.
- Either state goes to ST_IDLE in every other case.

A request is accepted in every cycle, including the cycle in which an earlier load's result is delivered. Stores complete in the cycle they are issued. The parameter `BIG_ENDIAN` sets the byte numbering inside a word.

Top module: `lsu_top`

## Requirements
- R1: Opcode 35 is a word load, 43 a word store, 32 a signed byte load, 36 an unsigned byte load and 40 a byte store.
- R2: The effective address is the base value plus the immediate sign-extended from 16 bits, covering offsets -32768 to 32767. `mem_addr` carries the effective address bits 31:2.
- R3: A word store drives `mem_we` in the same cycle as the request, with `mem_be` = 4'b1111 and `mem_wdata` equal to the store data.
- R4: A byte store drives `mem_we` with exactly one `mem_be` bit set and places store bits 7:0 in that lane. The other three bytes of the memory word keep their values.
- R5: With `BIG_ENDIAN`=1, byte offset 0 uses data bits 31:24 (enable bit 3) and offset 3 uses bits 7:0 (enable bit 0). With `BIG_ENDIAN`=0, offset 0 uses bits 7:0 (enable bit 0) and offset 3 uses bits 31:24 (enable bit 3).
- R6: A signed byte load returns the selected byte in bits 7:0, with bit 7 copied into bits 31:8.
- R7: An unsigned byte load returns the selected byte in bits 7:0, with zeros in bits 31:8.
- R8: A load raises `result_valid` in the cycle after the request, for that one cycle only, with the result on `result_data`. A word load returns the full memory word.
- R9: A word access whose effective address bits 1:0 are not 00 causes no memory read or write and no result. `misaligned` is high for exactly the following cycle.
- R10: Any other opcode causes no memory access. `illegal_op` is high for exactly the following cycle.
- R11: A new request issued in the same cycle that a load result is delivered is carried out, and it does not disturb that result.
- R12: During reset, `result_valid`, `misaligned` and `illegal_op` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Two's-complement offset |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 30 | Word address to memory |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_rdata | input | 32 | Read data from memory |
| result_valid | output | 1 | Load result present |
| result_data | output | 32 | Aligned, extended load result |
| misaligned | output | 1 | Misaligned word access flag |
| illegal_op | output | 1 | Unsupported opcode flag |

## Verification
Two functions can fall in the same cycle. One is the delivery of a load result from ST_LOAD_WAIT. The other is a new request, often a byte store to the word just read. The vector walk issues requests back to back, so every row after a load lands in the cycle that load's result is delivered.

The bench checks two things in that cycle. The delivered value must equal the word as it stood before the new store. The store's strobe and enables must appear at once. Later reads then confirm which bytes the store changed. Both endianness settings run the same vectors side by side.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam logic [5:0] OPC_LW  = 6'd35;
    localparam logic [5:0] OPC_SW  = 6'd43;
    localparam logic [5:0] OPC_LB  = 6'd32;
    localparam logic [5:0] OPC_LBU = 6'd36;
    localparam logic [5:0] OPC_SB  = 6'd40;

    typedef enum logic [2:0] {
        K_NONE, K_LW, K_SW, K_LB, K_LBU, K_SB
    } op_kind_e;

    typedef enum logic {
        ST_IDLE, ST_LOAD_WAIT
    } lsu_state_e;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [5:0] opcode,
    output op_kind_e   kind
);
    always_comb begin
        unique case (opcode)
            OPC_LW:  kind = K_LW;
            OPC_SW:  kind = K_SW;
            OPC_LB:  kind = K_LB;
            OPC_LBU: kind = K_LBU;
            OPC_SB:  kind = K_SB;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int DW    = 32,
    parameter int IMM_W = 16
) (
    input  logic [DW-1:0]              base,
    input  logic [IMM_W-1:0]           imm,
    output logic [DW-$clog2(DW/8)-1:0] word_addr,
    output logic [$clog2(DW/8)-1:0]    offset
);
    localparam int OFF_W = $clog2(DW/8);

    logic [DW-1:0] ea;

    always_comb begin
        ea        = base + {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
        word_addr = ea[DW-1:OFF_W];
        offset    = ea[OFF_W-1:0];
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter bit BIG_ENDIAN = 1'b1,
    parameter int DW         = 32
) (
    input  logic [$clog2(DW/8)-1:0] offset,
    input  logic                    is_word,
    input  logic [DW-1:0]           src,
    output logic [DW/8-1:0]         be,
    output logic [DW-1:0]           wdata
);
    localparam int BYTES = DW / 8;
    localparam int OFF_W = $clog2(BYTES);

    logic [OFF_W-1:0] lane;

    always_comb begin
        lane = BIG_ENDIAN ? (OFF_W'(BYTES - 1) - offset) : offset;
        for (int i = 0; i < BYTES; i++) begin
            be[i] = is_word | (lane == OFF_W'(i));
        end
        wdata = is_word ? src : {BYTES{src[7:0]}};
    end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1,
    parameter int DW         = 32
) (
    input  logic [DW-1:0]           rdata,
    input  logic [$clog2(DW/8)-1:0] offset,
    input  op_kind_e                kind,
    output logic [DW-1:0]           result
);
    localparam int BYTES = DW / 8;
    localparam int OFF_W = $clog2(BYTES);

    logic [OFF_W-1:0] lane;
    logic [7:0]       sel;

    always_comb begin
        lane = BIG_ENDIAN ? (OFF_W'(BYTES - 1) - offset) : offset;
        sel  = 8'h00;
        for (int i = 0; i < BYTES; i++) begin
            if (lane == OFF_W'(i)) sel = rdata[8*i +: 8];
        end
        unique case (kind)
            K_LB:    result = {{(DW-8){sel[7]}}, sel};
            K_LBU:   result = {{(DW-8){1'b0}}, sel};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1,
    parameter int DW         = 32,
    parameter int IMM_W      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [5:0]                 req_opcode,
    input  logic [DW-1:0]              req_base,
    input  logic [IMM_W-1:0]           req_imm,
    input  logic [DW-1:0]              req_wdata,
    output logic [DW-$clog2(DW/8)-1:0] mem_addr,
    output logic [DW/8-1:0]            mem_be,
    output logic [DW-1:0]              mem_wdata,
    output logic                       mem_we,
    output logic                       mem_re,
    input  logic [DW-1:0]              mem_rdata,
    output logic                       result_valid,
    output logic [DW-1:0]              result_data,
    output logic                       misaligned,
    output logic                       illegal_op
);
    localparam int BYTES = DW / 8;
    localparam int OFF_W = $clog2(BYTES);

    op_kind_e         kind;
    op_kind_e         pend_kind;
    lsu_state_e       state_q;
    lsu_state_e       state_d;
    logic [OFF_W-1:0] offset;
    logic [OFF_W-1:0] pend_off;
    logic [BYTES-1:0] lane_be;
    logic [DW-1:0]    lane_wdata;
    logic [DW-1:0]    aligned;
    logic             is_word;
    logic             is_load;
    logic             is_store;
    logic             bad_align;
    logic             take_load;
    logic             take_store;

    lsu_decode u_decode (
        .opcode (req_opcode),
        .kind   (kind)
    );

    lsu_agen #(.DW(DW), .IMM_W(IMM_W)) u_agen (
        .base      (req_base),
        .imm       (req_imm),
        .word_addr (mem_addr),
        .offset    (offset)
    );

    lsu_store_lane #(.BIG_ENDIAN(BIG_ENDIAN), .DW(DW)) u_store (
        .offset  (offset),
        .is_word (is_word),
        .src     (req_wdata),
        .be      (lane_be),
        .wdata   (lane_wdata)
    );

    lsu_load_align #(.BIG_ENDIAN(BIG_ENDIAN), .DW(DW)) u_load (
        .rdata  (mem_rdata),
        .offset (pend_off),
        .kind   (pend_kind),
        .result (aligned)
    );

    always_comb begin
        is_word    = (kind == K_LW) || (kind == K_SW);
        is_load    = (kind == K_LW) || (kind == K_LB) || (kind == K_LBU);
        is_store   = (kind == K_SW) || (kind == K_SB);
        bad_align  = is_word && (offset != '0);
        take_load  = req_valid && is_load && !bad_align;
        take_store = req_valid && is_store && !bad_align;
        state_d    = take_load ? ST_LOAD_WAIT : ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_off  <= '0;
            pend_kind <= K_NONE;
        end else begin
            state_q <= state_d;
            if (take_load) begin
                pend_off  <= offset;
                pend_kind <= kind;
            end
        end
    end

    // One-cycle flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misaligned <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            misaligned <= req_valid && bad_align;
            illegal_op <= req_valid && (kind == K_NONE);
        end
    end

    // Outputs
    always_comb begin
        mem_we       = take_store;
        mem_re       = take_load;
        mem_be       = take_store ? lane_be : (take_load ? '1 : '0);
        mem_wdata    = lane_wdata;
        result_valid = 1'b0;
        result_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD_WAIT: begin
                result_valid = 1'b1;
                result_data  = aligned;
            end
        endcase
    end

    // R8
    result_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(mem_re));

    // R9
    misalign_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> $past(!mem_we && !mem_re));

    // R10
    illegal_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> $past(!mem_we && !mem_re));

    // R4
    store_lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || mem_be == '1));

    // R6
    signed_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && pend_kind == K_LB) |-> (result_data[DW-1:8] == {(DW-8){result_data[7]}}));
endmodule

// File: tb/tb_lsu_top.sv
`timescale 1ns/100ps
module tb_lsu_top;
    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] base;
        logic [15:0] imm;
        logic [31:0] wd;
        logic [1:0]  kind;   // 0 store, 1 load, 2 misaligned, 3 illegal
        logic [31:0] exp_b;
        logic [31:0] exp_l;
        logic [3:0]  be_b;
        logic [3:0]  be_l;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{6'd43, 32'h0,        16'h0,    32'h23456789, 2'd0, 32'h0,        32'h0,        4'hF, 4'hF},
        '{6'd32, 32'h0,        16'h1,    32'h0,        2'd1, 32'h00000045, 32'h00000067, 4'h0, 4'h0},
        '{6'd36, 32'h4,        16'hFFFD, 32'h0,        2'd1, 32'h00000045, 32'h00000067, 4'h0, 4'h0},
        '{6'd40, 32'h10,       16'hFFF2, 32'h000000F0, 2'd0, 32'h0,        32'h0,        4'h2, 4'h4},
        '{6'd35, 32'h0,        16'h0,    32'h0,        2'd1, 32'h2345F089, 32'h23F06789, 4'h0, 4'h0},
        '{6'd32, 32'h0,        16'h2,    32'h0,        2'd1, 32'hFFFFFFF0, 32'hFFFFFFF0, 4'h0, 4'h0},
        '{6'd36, 32'h0,        16'h2,    32'h0,        2'd1, 32'h000000F0, 32'h000000F0, 4'h0, 4'h0},
        '{6'd32, 32'h0,        16'h3,    32'h0,        2'd1, 32'hFFFFFF89, 32'h00000023, 4'h0, 4'h0},
        '{6'd32, 32'h0,        16'h0,    32'h0,        2'd1, 32'h00000023, 32'hFFFFFF89, 4'h0, 4'h0},
        '{6'd43, 32'h4,        16'h2,    32'hDEADBEEF, 2'd2, 32'h0,        32'h0,        4'h0, 4'h0},
        '{6'd35, 32'h4,        16'h0,    32'h0,        2'd1, 32'h0,        32'h0,        4'h0, 4'h0},
        '{6'd35, 32'h0,        16'h1,    32'h0,        2'd2, 32'h0,        32'h0,        4'h0, 4'h0},
        '{6'd33, 32'h0,        16'h0,    32'h0,        2'd3, 32'h0,        32'h0,        4'h0, 4'h0},
        '{6'd43, 32'h00008010, 16'h8000, 32'hCAFEBABE, 2'd0, 32'h0,        32'h0,        4'hF, 4'hF},
        '{6'd35, 32'hFFFF8011, 16'h7FFF, 32'h0,        2'd1, 32'hCAFEBABE, 32'hCAFEBABE, 4'h0, 4'h0},
        '{6'd36, 32'h0,        16'h13,   32'h0,        2'd1, 32'h000000BE, 32'h000000CA, 4'h0, 4'h0},
        '{6'd40, 32'h10,       16'h0,    32'h12345677, 2'd0, 32'h0,        32'h0,        4'h8, 4'h1},
        '{6'd35, 32'h10,       16'h0,    32'h0,        2'd1, 32'h77FEBABE, 32'hCAFEBA77, 4'h0, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_opcode = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_imm = '0;
    logic [31:0] req_wdata = '0;

    logic [29:0] addr_b, addr_l;
    logic [3:0]  be_b, be_l;
    logic [31:0] wd_b, wd_l, rd_b, rd_l, res_b, res_l;
    logic        we_b, we_l, re_b, re_l, rv_b, rv_l, mis_b, mis_l, ill_b, ill_l;

    logic [31:0] mem_b [16];
    logic [31:0] mem_l [16];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsu_top #(.BIG_ENDIAN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
        .mem_addr(addr_b), .mem_be(be_b), .mem_wdata(wd_b), .mem_we(we_b), .mem_re(re_b),
        .mem_rdata(rd_b), .result_valid(rv_b), .result_data(res_b),
        .misaligned(mis_b), .illegal_op(ill_b));

    lsu_top #(.BIG_ENDIAN(1'b0)) dut_le (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
        .mem_addr(addr_l), .mem_be(be_l), .mem_wdata(wd_l), .mem_we(we_l), .mem_re(re_l),
        .mem_rdata(rd_l), .result_valid(rv_l), .result_data(res_l),
        .misaligned(mis_l), .illegal_op(ill_l));

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_b[i] = '0;
            mem_l[i] = '0;
        end
        rd_b = '0;
        rd_l = '0;
    end

    always @(posedge clk) begin
        if (re_b) rd_b <= mem_b[addr_b[3:0]];
        if (re_l) rd_l <= mem_l[addr_l[3:0]];
        for (int i = 0; i < 4; i++) begin
            if (we_b && be_b[i]) mem_b[addr_b[3:0]][8*i +: 8] <= wd_b[8*i +: 8];
            if (we_l && be_l[i]) mem_l[addr_l[3:0]][8*i +: 8] <= wd_l[8*i +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.kind == 2'd2) return "R9";
        if (v.kind == 2'd3) return "R10";
        case (v.op)
            6'd32:   return "R6";
            6'd36:   return "R7";
            6'd35:   return "R8";
            6'd43:   return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs low during reset
        chk("R12 rv", {30'd0, rv_b, rv_l}, 32'd0);
        chk("R12 flags", {28'd0, mis_b, mis_l, ill_b, ill_l}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R5 R11: vector walk, requests back to back over both endian settings
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            logic [31:0] ea;
            string t;
            v  = VEC[k];
            t  = tag_of(v);
            ea = v.base + {{16{v.imm[15]}}, v.imm};
            req_valid  = 1'b1;
            req_opcode = v.op;
            req_base   = v.base;
            req_imm    = v.imm;
            req_wdata  = v.wd;
            #1;
            chk({t, " we"}, {30'd0, we_b, we_l}, (v.kind == 2'd0) ? 32'd3 : 32'd0);
            if (v.kind == 2'd0) begin
                chk("R2 addr", {2'b00, addr_b}, {2'b00, ea[31:2]});
                chk({t, " R5 be big"}, {28'd0, be_b}, {28'd0, v.be_b});
                chk({t, " R5 be little"}, {28'd0, be_l}, {28'd0, v.be_l});
            end
            if (v.kind != 2'd1) chk({t, " re"}, {30'd0, re_b, re_l}, 32'd0);
            @(negedge clk);
            chk({t, " R8 valid"}, {30'd0, rv_b, rv_l}, (v.kind == 2'd1) ? 32'd3 : 32'd0);
            if (v.kind == 2'd1) begin
                chk({t, " R1 big"}, res_b, v.exp_b);
                chk({t, " R1 little"}, res_l, v.exp_l);
            end
            chk("R9 flag", {30'd0, mis_b, mis_l}, (v.kind == 2'd2) ? 32'd3 : 32'd0);
            chk("R10 flag", {30'd0, ill_b, ill_l}, (v.kind == 2'd3) ? 32'd3 : 32'd0);
        end

        // R8: no request -> result_valid drops after one cycle
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8 single pulse", {30'd0, rv_b, rv_l}, 32'd0);
        // R9 R10: flags last one cycle only
        chk("R9 R10 pulse", {28'd0, mis_b, mis_l, ill_b, ill_l}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule